// File: doc/BRIEF.md
# Histogram Packet Framer with Trigger-Latched Event Number

This block turns a stream of drained histogram bin words into one framed packet of 16-bit words. Each word carries a 2-bit status tag. A one-cycle `start_i` pulse, seen while the block is idle, begins a packet. The packet has three parts, in this order:

- a six-word header that carries the event number, the word count, a descriptor word, the card number and an event number latched by an external trigger;
- the data words, pulled from an upstream show-ahead FIFO one per clock through `data_rd_o`;
- a two-word trailer.

The block also watches two asynchronous trigger inputs, which are combined with a logical OR. The inputs are synchronised, and each rising edge of the combined signal stores the current event number once, however long the pulse lasts. Header words 5 and 6 then report that stored value.

The number of data words is set by parameters: links, histograms per link and bins per histogram. The word count and the link field in the header follow from the same parameters.

Top module: `hist_framer`

## Requirements
- R1: After reset, `valid_o` and `data_rd_o` are 0, and the stored trigger event number is 0. A packet started before any trigger reports 0 in its latched fields.
- R2: A `start_i` pulse sampled while idle makes `valid_o` high from the next clock edge on, for exactly 8 + data-word-count consecutive cycles. Header word 1 is {8'h00, evn[7:0]} and header word 2 is {4'h0, evn[19:8]}.
- R3: Header word 3 equals NUM_LINKS*HIST_PER_LINK*BINS + 8. With the default parameters this is 1544.
- R4: Header word 4 is {1'b1, mux, (NUM_LINKS-1) as 6 bits, 8'h02}.
- R5: Header word 5 is {latched[19:12], card[7:0]}. Header word 6 is {4'd5, latched[11:0]}.
- R6: `data_rd_o` is high for exactly the data-word count of consecutive cycles, starting in the cycle that shows header word 6. Each data word on `word_o` equals the `data_i` that was present in the previous cycle while `data_rd_o` was high.
- R7: Trailer word 1 is 16'h0000. Trailer word 2 is {evn[7:0], 8'h00}.
- R8: The status is 2'b11 on the first header word, 2'b01 on the final trailer word and 2'b10 on every other packet word.
- R9: A pulse on either trigger input, of any length of two or more cycles, stores the event number once. The value stored is the one present 3 clock edges after the pulse rises. Later changes of `evn_i` during the same pulse do not alter the stored value.
- R10: A `start_i` pulse that arrives while a packet is in progress is ignored. No second packet follows.
- R11: The event number, card number, mux bit and latched number are captured when the packet is accepted. Changes of `evn_i` during a packet do not affect its trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a packet (accepted only while idle) |
| evn_i | input | 20 | Current event number |
| card_num_i | input | 8 | Card number |
| mux_i | input | 1 | Link group selector bit |
| trig_a_i | input | 1 | Asynchronous trigger input A |
| trig_b_i | input | 1 | Asynchronous trigger input B |
| data_i | input | 16 | Show-ahead data word from upstream FIFO |
| data_rd_o | output | 1 | Consume the current `data_i` word |
| word_o | output | 16 | Packet word |
| status_o | output | 2 | Status tag of `word_o` |
| valid_o | output | 1 | `word_o` and `status_o` hold a packet word |

## Verification
The hardest case is a long trigger pulse during which the event number changes after the pulse has been detected. Only a framer that stores once per edge keeps the first value. To reach this, the stimulus holds a pulse on the second trigger input for 50 cycles and moves `evn_i` ten cycles into it. It then checks the latched header fields of the next packet. A separate packet changes `evn_i` and pulses `start_i` in the middle of the data phase. This shows at the ports that the trailer uses the captured snapshot and that no extra packet appears.

// File: rtl/hist_framer_pkg.sv
package hist_framer_pkg;
  localparam int EVN_W = 20;
  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_DATA, PH_TRL} phase_e;
  localparam logic [1:0] ST_FIRST = 2'b11;
  localparam logic [1:0] ST_MID   = 2'b10;
  localparam logic [1:0] ST_LAST  = 2'b01;
  localparam logic [7:0] MODE_HIST = 8'h02;
  localparam logic [3:0] TRIG_TYPE = 4'd5;
  localparam int HDR_WORDS = 6;
  localparam int TRL_WORDS = 2;
endpackage

// File: rtl/hf_trig_latch.sv
module hf_trig_latch
  import hist_framer_pkg::*;
#(
  parameter int N_TRIG      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [EVN_W-1:0]  evn_i,
  output logic [EVN_W-1:0]  evn_latched_o
);
  logic [N_TRIG-1:0] sync_top;
  logic any_q, prev_q;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[SYNC_STAGES-2:0], trig_i[g]};
    end
    assign sync_top[g] = chain_q[SYNC_STAGES-1];
  end

  assign any_q = |sync_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q        <= 1'b0;
      evn_latched_o <= '0;
    end else begin
      prev_q <= any_q;
      if (any_q && !prev_q) evn_latched_o <= evn_i;
    end
  end
endmodule

// File: rtl/hf_seq.sv
module hf_seq
  import hist_framer_pkg::*;
#(
  parameter int DATA_WORDS = 1536,
  localparam int CNT_W = $clog2(DATA_WORDS + HDR_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             accept_o
);
  phase_e phase_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = (phase_q == PH_IDLE) && start_i;
  assign phase_o  = phase_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_HDR;
          cnt_q   <= '0;
        end
        PH_HDR: if (cnt_q == CNT_W'(HDR_WORDS - 1)) begin
          phase_q <= PH_DATA;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_DATA: if (cnt_q == CNT_W'(DATA_WORDS - 1)) begin
          phase_q <= PH_TRL;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_TRL: if (cnt_q == CNT_W'(TRL_WORDS - 1)) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hf_word_mux.sv
module hf_word_mux
  import hist_framer_pkg::*;
#(
  parameter int NUM_LINKS   = 4,
  parameter int TOTAL_WORDS = 1544,
  parameter int CNT_W       = 11
) (
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [EVN_W-1:0] evn_i,
  input  logic [EVN_W-1:0] lat_i,
  input  logic [7:0]       card_i,
  input  logic             mux_i,
  input  logic [15:0]      data_i,
  output logic [15:0]      word_o,
  output logic [1:0]       status_o
);
  always_comb begin
    word_o   = 16'h0000;
    status_o = ST_MID;
    unique case (phase_i)
      PH_HDR: begin
        unique case (cnt_i[2:0])
          3'd0: begin word_o = {8'h00, evn_i[7:0]}; status_o = ST_FIRST; end
          3'd1: word_o = {4'h0, evn_i[19:8]};
          3'd2: word_o = 16'(TOTAL_WORDS);
          3'd3: word_o = {1'b1, mux_i, 6'(NUM_LINKS - 1), MODE_HIST};
          3'd4: word_o = {lat_i[19:12], card_i};
          default: word_o = {TRIG_TYPE, lat_i[11:0]};
        endcase
      end
      PH_DATA: word_o = data_i;
      PH_TRL: begin
        if (cnt_i[0]) begin
          word_o   = {evn_i[7:0], 8'h00};
          status_o = ST_LAST;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/hist_framer.sv
module hist_framer
  import hist_framer_pkg::*;
#(
  parameter int NUM_LINKS     = 4,
  parameter int HIST_PER_LINK = 12,
  parameter int BINS          = 32,
  parameter int SYNC_STAGES   = 2,
  localparam int DATA_WORDS  = NUM_LINKS * HIST_PER_LINK * BINS,
  localparam int TOTAL_WORDS = DATA_WORDS + HDR_WORDS + TRL_WORDS,
  localparam int CNT_W       = $clog2(DATA_WORDS + HDR_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [EVN_W-1:0] evn_i,
  input  logic [7:0]       card_num_i,
  input  logic             mux_i,
  input  logic             trig_a_i,
  input  logic             trig_b_i,
  input  logic [15:0]      data_i,
  output logic             data_rd_o,
  output logic [15:0]      word_o,
  output logic [1:0]       status_o,
  output logic             valid_o
);
  phase_e phase_w;
  logic [CNT_W-1:0] cnt_w;
  logic accept_w;
  logic [EVN_W-1:0] lat_w, evn_q, lat_q;
  logic [7:0] card_q;
  logic mux_q;
  logic [15:0] word_w;
  logic [1:0] status_w;

  hf_trig_latch #(.N_TRIG(2), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i, .rst_ni, .trig_i({trig_b_i, trig_a_i}), .evn_i, .evn_latched_o(lat_w)
  );

  hf_seq #(.DATA_WORDS(DATA_WORDS)) u_seq (
    .clk_i, .rst_ni, .start_i, .phase_o(phase_w), .cnt_o(cnt_w), .accept_o(accept_w)
  );

  // snapshot keeps one packet self-consistent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evn_q <= '0; lat_q <= '0; card_q <= '0; mux_q <= 1'b0;
    end else if (accept_w) begin
      evn_q <= evn_i; lat_q <= lat_w; card_q <= card_num_i; mux_q <= mux_i;
    end
  end

  hf_word_mux #(.NUM_LINKS(NUM_LINKS), .TOTAL_WORDS(TOTAL_WORDS), .CNT_W(CNT_W)) u_mux (
    .phase_i(phase_w), .cnt_i(cnt_w), .evn_i(evn_q), .lat_i(lat_q),
    .card_i(card_q), .mux_i(mux_q), .data_i, .word_o(word_w), .status_o(status_w)
  );

  assign data_rd_o = (phase_w == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; word_o <= '0; status_o <= '0;
    end else begin
      valid_o  <= (phase_w != PH_IDLE);
      word_o   <= word_w;
      status_o <= (phase_w != PH_IDLE) ? status_w : 2'b00;
    end
  end
endmodule

// File: rtl/hist_framer_chk.sv
module hist_framer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_o,
  input logic [1:0]  status_o,
  input logic [15:0] word_o,
  input logic        data_rd_o,
  input logic [15:0] data_i
);
  AST_FIRST_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> status_o == 2'b11); // R8
  AST_LAST_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $past(status_o) == 2'b01); // R8
  AST_DATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(data_rd_o) |-> (valid_o && status_o == 2'b10 && word_o == $past(data_i))); // R6
  AST_HDR2_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_o) && $past(status_o) == 2'b11) |-> (valid_o && word_o[15:12] == 4'h0)); // R2
  AST_TRL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && status_o == 2'b01) |-> word_o[7:0] == 8'h00); // R7
  AST_RD_IN_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_o |-> valid_o); // R6
endmodule

bind hist_framer hist_framer_chk u_chk (
  .clk_i, .rst_ni, .valid_o, .status_o, .word_o, .data_rd_o, .data_i
);

// File: tb/hist_framer_tb_top.sv
module hist_framer_tb_top;
  localparam int NL = 4, HPL = 12, BINS = 32;
  localparam int DW = NL * HPL * BINS;
  localparam int TOT = DW + 8;

  typedef struct {
    bit v; bit rd; logic [1:0] st; logic [15:0] w; string tag;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0, mux = 0, trig_a = 0, trig_b = 0;
  logic [19:0] evn = '0;
  logic [7:0] card = '0;
  logic [15:0] data;
  logic data_rd, valid;
  logic [15:0] word;
  logic [1:0] status;

  int n_cmp = 0, n_bad = 0, rd_cnt = 0;
  bit checking = 0, finished = 0;
  exp_t q[$];
  logic [19:0] exp_lat = '0;
  string idle_tag = "R1", lat_tag = "R1", trl_tag = "R7";

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(int k);
    return 16'((k * 40503 + 7) ^ (k >> 3));
  endfunction

  assign data = pat(rd_cnt);

  hist_framer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .evn_i(evn), .card_num_i(card),
    .mux_i(mux), .trig_a_i(trig_a), .trig_b_i(trig_b), .data_i(data),
    .data_rd_o(data_rd), .word_o(word), .status_o(status), .valid_o(valid)
  );

  always @(posedge clk) if (rst_n && data_rd) rd_cnt <= rd_cnt + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking && !finished) begin
    exp_t e;
    if (q.size() > 0) e = q.pop_front();
    else begin e.v = 0; e.rd = 0; e.st = 0; e.w = 0; e.tag = idle_tag; end
    chk(e.v ? e.tag : idle_tag, {31'd0, valid}, {31'd0, e.v});
    chk(e.v ? "R6" : idle_tag, {31'd0, data_rd}, {31'd0, e.rd});
    if (e.v) begin
      chk(e.tag, {16'd0, word}, {16'd0, e.w});
      chk("R8", {30'd0, status}, {30'd0, e.st});
    end
  end

  task automatic push_pkt(logic [19:0] ev, logic [7:0] cd, logic mx, logic [19:0] lt, int base);
    exp_t e;
    e.v = 0; e.rd = 0; e.st = 0; e.w = 0; e.tag = idle_tag;
    q.push_back(e);
    for (int k = 0; k < TOT; k++) begin
      e.v = 1; e.rd = (k >= 5) && (k <= DW + 4);
      e.st = (k == 0) ? 2'b11 : (k == TOT - 1) ? 2'b01 : 2'b10;
      if (k == 0)            begin e.w = {8'h00, ev[7:0]}; e.tag = "R2"; end
      else if (k == 1)       begin e.w = {4'h0, ev[19:8]}; e.tag = "R2"; end
      else if (k == 2)       begin e.w = 16'(TOT); e.tag = "R3"; end
      else if (k == 3)       begin e.w = {1'b1, mx, 6'(NL - 1), 8'h02}; e.tag = "R4"; end
      else if (k == 4)       begin e.w = {lt[19:12], cd}; e.tag = "R5"; end
      else if (k == 5)       begin e.w = {4'd5, lt[11:0]}; e.tag = lat_tag; end
      else if (k < 6 + DW)   begin e.w = pat(base + k - 6); e.tag = "R6"; end
      else if (k == TOT - 2) begin e.w = 16'h0000; e.tag = "R7"; end
      else                   begin e.w = {ev[7:0], 8'h00}; e.tag = trl_tag; end
      q.push_back(e);
    end
  endtask

  task automatic start_pkt();
    @(negedge clk) start = 1;
    @(posedge clk);
    push_pkt(evn, card, mux, exp_lat, rd_cnt);
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done();
    while (q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    checking = 1;
    repeat (4) @(negedge clk);           // R1 idle after reset
    // R1 latched fields zero, R2..R8 main packet
    evn = 20'h12345; card = 8'hA5; mux = 0;
    start_pkt();
    wait_done();

    // R9 trigger on input A
    evn = 20'h0ABCD;
    @(negedge clk) trig_a = 1;
    repeat (5) @(negedge clk);
    trig_a = 0;
    exp_lat = 20'h0ABCD;
    repeat (8) @(negedge clk);
    evn = 20'h54321; card = 8'h3C; mux = 1;
    lat_tag = "R9"; trl_tag = "R11";
    start_pkt();
    repeat (100) @(negedge clk);
    evn = 20'hFFFFF;                      // R11 snapshot
    idle_tag = "R10";
    start = 1;                            // R10 stray start
    @(negedge clk) start = 0;
    wait_done();
    repeat (20) @(negedge clk);

    // R9 long pulse on input B, evn moves mid-pulse
    trl_tag = "R7";
    evn = 20'h77777;
    @(negedge clk) trig_b = 1;
    repeat (10) @(negedge clk);
    evn = 20'h11111;
    repeat (40) @(negedge clk);
    trig_b = 0;
    exp_lat = 20'h77777;
    repeat (8) @(negedge clk);
    card = 8'h01; mux = 0;
    start_pkt();
    wait_done();
    finish_up();
  end
endmodule